// File: doc/BRIEF.md
# Atomic Swap Spin-Lock Unit

This block holds one shared lock word and serves a set of requesting processor ports over a single shared access path. Each port may read the lock, perform an indivisible swap that returns the previous lock value while leaving the lock set, or release the lock by writing zero. A round-robin arbiter admits one port per cycle, so simultaneous attempts are forced into a sequence. Of all the contenders that swap after a release, exactly one observes the free value.

A response comes back to the granted port one cycle after its grant and carries the old lock value. A port whose swap found the lock free also gets a one-cycle acquired pulse in that same cycle. The unit records which port holds the lock. A release attempt from any other port, or a release while the lock is already free, leaves the lock unchanged and produces an error pulse. Software normally polls with plain reads and tries a swap only after it has read zero.

Top module: `swap_lock_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, grant, rsp_valid, rsp_data, acquired and unlock_err are all 0. The lock comes out of reset free, so the first read returns 0.
- R2: At most one bit of grant is set in a cycle, and only for a port whose req_valid is set. grant is combinational from the current requests.
- R3: The grant goes to the first requesting port found by scanning upward, with wrap-around, from the port after the most recently granted one. After reset the scan starts at port 0. A port that holds its request is therefore granted within NPORTS cycles.
- R4: In the cycle after a grant to port i, rsp_valid[i] is 1 and rsp_data[i] holds the lock value from before the operation. In every other cycle rsp_valid[i] and rsp_data[i] are 0.
- R5: Op code 2'b01 (swap) leaves the lock at 1 whatever its old value was. If the old value was 0, the granted port becomes the owner and acquired[i] pulses together with its response.
- R6: Among swaps that follow one release, only one port sees 0 and pulses acquired. All later swaps return 1. acquired is never set for two ports in one cycle, and never set twice without a release in between.
- R7: Op code 2'b00 (read) returns the lock value and changes neither the lock nor the owner.
- R8: Op code 2'b10 (unlock) from the owning port clears the lock to 0. A later read or swap then sees 0.
- R9: An unlock from a port that is not the owner, or an unlock while the lock is free, leaves the lock unchanged. It pulses unlock_err[i] together with that port's response.
- R10: Op code 2'b11 behaves exactly like a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Per-port request, held until granted |
| req_op | input | 2*NPORTS | Per-port op code, port i in bits [2i+1:2i] |
| grant | output | NPORTS | One-hot grant of the current cycle |
| rsp_valid | output | NPORTS | Response strobe, one cycle after grant |
| rsp_data | output | NPORTS | Lock value from before the granted operation |
| acquired | output | NPORTS | Pulse: the swap of this port obtained the lock |
| unlock_err | output | NPORTS | Pulse: the unlock of this port was refused |

## Verification
Two things can fall in the same cycle: a release by the owner and swaps from several waiting ports. Only the arbiter's order decides whether a given swap lands before or after the release. The bench provokes this on purpose. It issues the owner's unlock in the same cycle as swaps from all other ports, and it runs spinning agents that poll, swap after reading zero, hold the lock and release it. A cycle-accurate behavioural model applies the grants one at a time, in round-robin order, to its own lock and owner variables. Every grant, response value, acquired pulse and error pulse is compared against that model on every clock.

// File: rtl/swl_pkg.sv
package swl_pkg;

   typedef enum logic [1:0] {
      OP_READ   = 2'b00,
      OP_SWAP   = 2'b01,
      OP_UNLOCK = 2'b10,
      OP_RSVD   = 2'b11
   } swl_op_e;

   localparam int OP_W = 2;

endpackage

// File: rtl/swl_rr_arbiter.sv
module swl_rr_arbiter #(
   parameter int NPORTS = 4,
   localparam int IDXW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] req,
   output logic [NPORTS-1:0] gnt,
   output logic [IDXW-1:0]   gnt_idx,
   output logic              gnt_any
);

   logic [IDXW-1:0] last_q;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      gnt_any = 1'b0;
      for (int k = 1; k <= NPORTS; k++) begin
         int p;
         p = (int'(last_q) + k) % NPORTS;
         if (!gnt_any && req[p]) begin
            gnt_any = 1'b1;
            gnt_idx = IDXW'(p);
         end
      end
      if (gnt_any) gnt[gnt_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= IDXW'(NPORTS - 1);
      else if (gnt_any) last_q <= gnt_idx;
   end

endmodule

// File: rtl/swl_lock_core.sv
module swl_lock_core
   import swl_pkg::*;
#(
   parameter int NPORTS = 4,
   localparam int IDXW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gnt_any,
   input  logic [IDXW-1:0] gnt_idx,
   input  swl_op_e         op,
   output logic            old_val,
   output logic            acq_now,
   output logic            err_now
);

   logic            lock_q, lock_d;
   logic [IDXW-1:0] owner_q, owner_d;

   always_comb begin
      old_val = lock_q;
      lock_d  = lock_q;
      owner_d = owner_q;
      acq_now = 1'b0;
      err_now = 1'b0;
      if (gnt_any) begin
         unique case (op)
            OP_SWAP: begin
               lock_d = 1'b1;
               if (!lock_q) begin
                  acq_now = 1'b1;
                  owner_d = gnt_idx;
               end
            end
            OP_UNLOCK: begin
               if (lock_q && (owner_q == gnt_idx)) lock_d  = 1'b0;
               else                                err_now = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         owner_q <= '0;
      end else begin
         lock_q  <= lock_d;
         owner_q <= owner_d;
      end
   end

endmodule

// File: rtl/swl_resp_stage.sv
module swl_resp_stage #(
   parameter int NPORTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] gnt,
   input  logic              old_val,
   input  logic              acq_now,
   input  logic              err_now,
   output logic [NPORTS-1:0] rsp_valid,
   output logic [NPORTS-1:0] rsp_data,
   output logic [NPORTS-1:0] acquired,
   output logic [NPORTS-1:0] unlock_err
);

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid[i]  <= 1'b0;
            rsp_data[i]   <= 1'b0;
            acquired[i]   <= 1'b0;
            unlock_err[i] <= 1'b0;
         end else begin
            rsp_valid[i]  <= gnt[i];
            rsp_data[i]   <= gnt[i] & old_val;
            acquired[i]   <= gnt[i] & acq_now;
            unlock_err[i] <= gnt[i] & err_now;
         end
      end
   end

endmodule

// File: rtl/swap_lock_unit.sv
module swap_lock_unit
   import swl_pkg::*;
#(
   parameter int NPORTS = 4,
   localparam int IDXW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORTS-1:0]      req_valid,
   input  logic [OP_W*NPORTS-1:0] req_op,
   output logic [NPORTS-1:0]      grant,
   output logic [NPORTS-1:0]      rsp_valid,
   output logic [NPORTS-1:0]      rsp_data,
   output logic [NPORTS-1:0]      acquired,
   output logic [NPORTS-1:0]      unlock_err
);

   if (NPORTS < 2) begin : g_chk_ports
      $error("swap_lock_unit: NPORTS must be at least 2");
   end
   if (NPORTS > 64) begin : g_chk_ports_max
      $error("swap_lock_unit: NPORTS must not exceed 64");
   end

   logic [IDXW-1:0] gnt_idx;
   logic            gnt_any;
   swl_op_e         op_sel;
   logic            old_val, acq_now, err_now;

   swl_rr_arbiter #(.NPORTS(NPORTS)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_valid),
      .gnt     (grant),
      .gnt_idx (gnt_idx),
      .gnt_any (gnt_any)
   );

   assign op_sel = swl_op_e'(req_op[int'(gnt_idx)*OP_W +: OP_W]);

   swl_lock_core #(.NPORTS(NPORTS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx),
      .op      (op_sel),
      .old_val (old_val),
      .acq_now (acq_now),
      .err_now (err_now)
   );

   swl_resp_stage #(.NPORTS(NPORTS)) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt        (grant),
      .old_val    (old_val),
      .acq_now    (acq_now),
      .err_now    (err_now),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .acquired   (acquired),
      .unlock_err (unlock_err)
   );

endmodule

// File: rtl/swl_checker.sv
module swl_checker #(
   parameter int NPORTS = 4,
   localparam int CW    = $clog2(NPORTS + 1) + 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NPORTS-1:0]   req_valid,
   input logic [2*NPORTS-1:0] req_op,
   input logic [NPORTS-1:0]   grant,
   input logic [NPORTS-1:0]   rsp_valid,
   input logic [NPORTS-1:0]   rsp_data,
   input logic [NPORTS-1:0]   acquired,
   input logic [NPORTS-1:0]   unlock_err
);

   logic held_q;
   logic [NPORTS-1:0] unl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         unl_q  <= '0;
      end else begin
         for (int i = 0; i < NPORTS; i++)
            unl_q[i] <= grant[i] && (req_op[2*i +: 2] == 2'b10);
         if (acquired != '0) held_q <= 1'b1;
         else if ((rsp_valid & unl_q & ~unlock_err) != '0) held_q <= 1'b0;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2
   AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_valid) == '0); // R2
   AST_ACQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acquired)); // R6
   AST_NO_DOUBLE_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
      (acquired != '0) |-> !held_q); // R6

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      logic [CW-1:0] wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        wait_q <= '0;
         else if (req_valid[i] && !grant[i]) wait_q <= wait_q + 1'b1;
         else                               wait_q <= '0;
      end
      AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[i] && !grant[i]) |-> (wait_q < CW'(NPORTS - 1))); // R3
      AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |=> rsp_valid[i]); // R4
      AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
         !grant[i] |=> !rsp_valid[i]); // R4
      AST_ACQ_SAW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
         acquired[i] |-> (rsp_valid[i] && !rsp_data[i])); // R5
      AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
         unlock_err[i] |-> rsp_valid[i]); // R9
   end

endmodule

bind swap_lock_unit swl_checker #(.NPORTS(NPORTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .grant      (grant),
   .rsp_valid  (rsp_valid),
   .rsp_data   (rsp_data),
   .acquired   (acquired),
   .unlock_err (unlock_err)
);

// File: tb/sim_swap_lock_unit.sv
module sim_swap_lock_unit;

   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   req_valid = '0;
   logic [2*N-1:0] req_op = '0;
   logic [N-1:0]   grant, rsp_valid, rsp_data, acquired, unlock_err;

   always #5 clk = ~clk;

   swap_lock_unit #(.NPORTS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .grant(grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .acquired(acquired), .unlock_err(unlock_err)
   );

   int tests = 0, fails = 0;
   bit done = 0;

   // model state
   int m_lock, m_owner, m_last;
   bit e_rv[N], e_rd[N], e_acq[N], e_err[N];
   int e_op[N];
   // pending requests
   bit pend_v[N];
   int pend_op[N];
   // agents
   int mode = 0;
   int ag_st[N], hold[N];
   bit busy[N];

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string data_tag(int op);
      case (op)
         0: return "R7 read data";
         1: return "R5 swap old value";
         2: return "R8 unlock old value";
         default: return "R10 reserved op data";
      endcase
   endfunction

   task automatic model_reset();
      m_lock = 0; m_owner = 0; m_last = N - 1;
      for (int i = 0; i < N; i++) begin
         e_rv[i] = 0; e_rd[i] = 0; e_acq[i] = 0; e_err[i] = 0; e_op[i] = 0;
         pend_v[i] = 0; pend_op[i] = 0; ag_st[i] = 0; hold[i] = 0; busy[i] = 0;
      end
   endtask

   task automatic agents();
      for (int i = 0; i < N; i++) begin
         if (rsp_valid[i]) begin
            busy[i] = 0;
            if (mode == 1) begin
               if (e_op[i] == 0) ag_st[i] = rsp_data[i] ? 0 : 1;
               else if (e_op[i] == 1) begin
                  if (acquired[i]) begin ag_st[i] = 2; hold[i] = 1 + int'($urandom % 4); end
                  else ag_st[i] = 0;
               end else ag_st[i] = 0;
            end
         end
         if (mode == 1 && !pend_v[i] && !busy[i]) begin
            if (ag_st[i] == 0) begin pend_v[i] = 1; pend_op[i] = 0; end
            else if (ag_st[i] == 1) begin pend_v[i] = 1; pend_op[i] = 1; end
            else if (hold[i] > 0) hold[i]--;
            else begin pend_v[i] = 1; pend_op[i] = 2; end
         end
         if (mode == 2 && !pend_v[i] && ($urandom % 3 == 0)) begin
            pend_v[i] = 1; pend_op[i] = int'($urandom % 4);
         end
      end
   endtask

   task automatic step();
      int g;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         chk("R4 rsp_valid", rsp_valid[i], e_rv[i]);
         chk(e_rv[i] ? data_tag(e_op[i]) : "R4 idle data", rsp_data[i], e_rd[i]);
         chk("R6 acquired", acquired[i], e_acq[i]);
         chk("R9 unlock_err", unlock_err[i], e_err[i]);
      end
      agents();
      for (int i = 0; i < N; i++) begin
         req_valid[i]      = pend_v[i];
         req_op[2*i +: 2]  = 2'(pend_op[i]);
      end
      #1;
      g = -1;
      for (int k = 1; k <= N; k++) begin
         int p;
         p = (m_last + k) % N;
         if (g < 0 && pend_v[p]) g = p;
      end
      for (int i = 0; i < N; i++) begin
         chk("R2 R3 grant", grant[i], (g == i) ? 1 : 0);
         e_rv[i] = 0; e_rd[i] = 0; e_acq[i] = 0; e_err[i] = 0;
      end
      if (g >= 0) begin
         e_rv[g] = 1; e_rd[g] = m_lock[0]; e_op[g] = pend_op[g];
         if (pend_op[g] == 1) begin
            if (m_lock == 0) begin e_acq[g] = 1; m_owner = g; end
            m_lock = 1;
         end else if (pend_op[g] == 2) begin
            if (m_lock == 1 && m_owner == g) m_lock = 0;
            else e_err[g] = 1;
         end
         m_last = g; pend_v[g] = 0; busy[g] = 1;
      end
   endtask

   task automatic issue(int p, int op);
      pend_v[p] = 1; pend_op[p] = op;
   endtask

   task automatic drain();
      for (int c = 0; c < 3 * N; c++) step();
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset grant", int'(grant), 0);
      chk("R1 reset rsp_valid", int'(rsp_valid), 0);
      chk("R1 reset acquired", int'(acquired | unlock_err | rsp_data), 0);
      rst_n = 1'b1;
      // first read after reset sees free lock
      issue(2, 0); drain();
      // owner swap, reader, foreign unlock, owner unlock, unlock when free
      issue(0, 1); drain();
      issue(1, 0); drain();
      issue(2, 2); drain();
      issue(3, 3); drain();
      issue(0, 2); drain();
      issue(3, 2); drain();
      // all ports swap at once, several rounds
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < N; i++) issue(i, 1);
         drain();
         issue(m_owner, 2); drain();
      end
      // owner release in the same cycle as swaps from the others
      issue(1, 1); drain();
      for (int r = 0; r < 4; r++) begin
         int o;
         o = m_owner;
         for (int i = 0; i < N; i++) issue(i, (i == o) ? 2 : 1);
         drain();
      end
      // spinning agents
      mode = 1;
      for (int c = 0; c < 3000; c++) step();
      mode = 0;
      for (int c = 0; c < 20; c++) step();
      // random traffic including reserved op
      mode = 2;
      for (int c = 0; c < 3000; c++) step();
      mode = 0;
      drain();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule